// File: doc/BRIEF.md
# Vector 128-bit Half Permute Unit

This block rearranges the two 128-bit halves of a 256-bit vector. It takes two 256-bit sources (A and B), a 128-bit operand (H), a 2-bit operation select, a one-bit half index and an 8-bit control immediate. From these it forms a 256-bit result. It can do four things:

- permute halves taken from both sources, with a zero option for each half;
- insert H into one half of A;
- extract one half of A;
- broadcast H to both halves.

The datapath is combinational. A parameter adds a one-cycle output register that loads on a valid strobe. A vector execution pipeline uses the block as its cross-half data-movement stage. The caller presents operands with `in_valid` and reads `result` when `out_valid` is high.

Top module: `vhp_unit`

## Requirements
- R1: With op_sel = 2'b00 (permute), imm[1:0] picks the lower result half and imm[5:4] picks the upper result half. Code 0 is A[127:0], code 1 is A[255:128], code 2 is B[127:0] and code 3 is B[255:128].
- R2: In permute, imm[3] = 1 forces result[127:0] to zero and imm[7] = 1 forces result[255:128] to zero, whatever the select code.
- R3: In permute, imm[2] and imm[6] have no effect on the result.
- R4: With op_sel = 2'b01 (insert), the result equals A with one half replaced by H. `hsel` = 0 replaces the lower half and `hsel` = 1 replaces the upper half.
- R5: With op_sel = 2'b10 (extract), result[127:0] is A[127:0] when `hsel` = 0 and A[255:128] when `hsel` = 1. result[255:128] is zero.
- R6: With op_sel = 2'b11 (broadcast), both result halves equal H.
- R7: Inputs that an operation does not name have no effect on the result:
  - imm and B for insert, extract and broadcast;
  - `hsel` for permute and broadcast;
  - H for permute and extract.
- R8: With OUT_REG = 0, `out_valid` equals `in_valid` and `result` follows the inputs in the same cycle. With OUT_REG = 1:
  - `result` and `out_valid` appear one clock after `in_valid` is sampled;
  - `out_valid` is 0 and `result` is zero after reset;
  - `result` holds its value across cycles in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used only when OUT_REG = 1) |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 00 permute, 01 insert, 10 extract, 11 broadcast |
| imm | input | 8 | Permute control: select codes and zero bits |
| hsel | input | 1 | Half index for insert and extract (0 lower, 1 upper) |
| src_a | input | 256 | Source vector A |
| src_b | input | 256 | Source vector B |
| src_h | input | 128 | 128-bit operand for insert and broadcast |
| out_valid | output | 1 | Result is valid |
| result | output | 256 | 256-bit result |

## Verification
The bound checker checks the following on every clock edge, against the operands that produced the current output:
- broadcast duplicates H into both halves;
- extract clears the upper half;
- the permute zero bits clear their half;
- insert keeps the half of A it does not replace;
- `out_valid` tracks the strobe with the configured latency;
- in the registered variant, the result is stable across idle cycles.

Only the bench's scenarios can show the following:
- every one of the sixteen permute code pairs routes the correct source half;
- the reserved immediate bits and the unused inputs leave the result unchanged (each result is compared against a baseline on the same data);
- extract picks the correct half of A.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

    typedef enum logic [1:0] {
        OP_PERM  = 2'b00,
        OP_INS   = 2'b01,
        OP_EXT   = 2'b10,
        OP_BCAST = 2'b11
    } vhp_op_e;

    // Per-half control nibble inside the permute immediate:
    // bits [1:0] source code, bit 2 unused, bit 3 zero force.
    localparam int unsigned CTRL_NIB_W = 4;
    localparam int unsigned CODE_LSB   = 0;
    localparam int unsigned ZERO_BIT   = 3;
    localparam int unsigned NUM_HALVES = 2;
    localparam int unsigned NUM_CANDS  = 4;

endpackage

// File: rtl/vhp_half_pick.sv
module vhp_half_pick #(
    parameter int unsigned HALF_W = 128
) (
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] a_hi,
    input  logic [HALF_W-1:0] b_lo,
    input  logic [HALF_W-1:0] b_hi,
    input  logic [1:0]        code,
    input  logic              zero,
    output logic [HALF_W-1:0] half_out
);

    logic [HALF_W-1:0] pick_d;

    always_comb begin
        unique case (code)
            2'd0:    pick_d = a_lo;
            2'd1:    pick_d = a_hi;
            2'd2:    pick_d = b_lo;
            default: pick_d = b_hi;
        endcase
        half_out = zero ? '0 : pick_d;
    end

endmodule

// File: rtl/vhp_core.sv
module vhp_core
    import vhp_pkg::*;
#(
    parameter int unsigned HALF_W = 128,
    localparam int unsigned VEC_W = 2 * HALF_W
) (
    input  logic [1:0]       op_sel,
    input  logic [7:0]       imm,
    input  logic             hsel,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [HALF_W-1:0] src_h,
    output logic [VEC_W-1:0] vec_d
);

    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [VEC_W-1:0]  perm_d;
    logic              unused_rsv;

    assign a_lo = src_a[HALF_W-1:0];
    assign a_hi = src_a[VEC_W-1:HALF_W];
    assign b_lo = src_b[HALF_W-1:0];
    assign b_hi = src_b[VEC_W-1:HALF_W];

    // reserved bits of each control nibble
    assign unused_rsv = ^{imm[2], imm[6]};

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        vhp_half_pick #(.HALF_W(HALF_W)) u_pick (
            .a_lo     (a_lo),
            .a_hi     (a_hi),
            .b_lo     (b_lo),
            .b_hi     (b_hi),
            .code     (imm[g*CTRL_NIB_W+CODE_LSB +: 2]),
            .zero     (imm[g*CTRL_NIB_W+ZERO_BIT]),
            .half_out (perm_d[g*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        vec_d = '0;
        unique case (vhp_op_e'(op_sel))
            OP_PERM: vec_d = perm_d;
            OP_INS: begin
                vec_d = src_a;
                if (hsel) vec_d[VEC_W-1:HALF_W] = src_h;
                else      vec_d[HALF_W-1:0]     = src_h;
            end
            OP_EXT:   vec_d[HALF_W-1:0] = hsel ? a_hi : a_lo;
            default:  vec_d = {src_h, src_h};
        endcase
    end

endmodule

// File: rtl/vhp_out_stage.sv
module vhp_out_stage #(
    parameter int unsigned VEC_W   = 256,
    parameter bit          OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_in,
    input  logic [VEC_W-1:0] data_in,
    output logic             vld_out,
    output logic [VEC_W-1:0] data_out
);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } stage_t;

    if (OUT_REG) begin : g_reg
        stage_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = vld_in;
            if (vld_in) st_d.data = data_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign vld_out  = st_q.vld;
        assign data_out = st_q.data;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign vld_out    = vld_in;
        assign data_out   = data_in;
    end

endmodule

// File: rtl/vhp_unit.sv
module vhp_unit #(
    parameter int unsigned HALF_W  = 128,
    parameter bit          OUT_REG = 1'b0,
    localparam int unsigned VEC_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [7:0]        imm,
    input  logic              hsel,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [HALF_W-1:0] src_h,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);

    logic [VEC_W-1:0] vec_d;

    vhp_core #(.HALF_W(HALF_W)) u_core (
        .op_sel (op_sel),
        .imm    (imm),
        .hsel   (hsel),
        .src_a  (src_a),
        .src_b  (src_b),
        .src_h  (src_h),
        .vec_d  (vec_d)
    );

    vhp_out_stage #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_in   (in_valid),
        .data_in  (vec_d),
        .vld_out  (out_valid),
        .data_out (result)
    );

endmodule

module vhp_unit_chk #(
    parameter int unsigned HALF_W  = 128,
    parameter bit          OUT_REG = 1'b0,
    localparam int unsigned VEC_W  = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic [7:0]        imm,
    input logic              hsel,
    input logic [VEC_W-1:0]  src_a,
    input logic [HALF_W-1:0] src_h,
    input logic              out_valid,
    input logic [VEC_W-1:0]  result
);

    logic              obs_vld;
    logic [1:0]        obs_op;
    logic [7:0]        obs_imm;
    logic              obs_hsel;
    logic [VEC_W-1:0]  obs_a;
    logic [HALF_W-1:0] obs_h;

    if (OUT_REG) begin : g_obs_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                obs_vld  <= 1'b0;
                obs_op   <= '0;
                obs_imm  <= '0;
                obs_hsel <= 1'b0;
                obs_a    <= '0;
                obs_h    <= '0;
            end else begin
                obs_vld <= in_valid;
                if (in_valid) begin
                    obs_op   <= op_sel;
                    obs_imm  <= imm;
                    obs_hsel <= hsel;
                    obs_a    <= src_a;
                    obs_h    <= src_h;
                end
            end
        end

        // R8
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
    end else begin : g_obs_comb
        assign obs_vld  = in_valid;
        assign obs_op   = op_sel;
        assign obs_imm  = imm;
        assign obs_hsel = hsel;
        assign obs_a    = src_a;
        assign obs_h    = src_h;
    end

    // R8
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == obs_vld);

    // R6
    bcast_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_vld && obs_op == 2'b11) |-> (result == {obs_h, obs_h}));

    // R5
    extract_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_vld && obs_op == 2'b10) |-> (result[VEC_W-1:HALF_W] == '0));

    // R2
    perm_zero_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_vld && obs_op == 2'b00 && obs_imm[3]) |-> (result[HALF_W-1:0] == '0));

    // R2
    perm_zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_vld && obs_op == 2'b00 && obs_imm[7]) |-> (result[VEC_W-1:HALF_W] == '0));

    // R4
    insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_vld && obs_op == 2'b01) |->
        (obs_hsel ? (result == {obs_h, obs_a[HALF_W-1:0]})
                  : (result == {obs_a[VEC_W-1:HALF_W], obs_h})));

endmodule

bind vhp_unit vhp_unit_chk #(.HALF_W(HALF_W), .OUT_REG(OUT_REG)) u_vhp_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .imm       (imm),
    .hsel      (hsel),
    .src_a     (src_a),
    .src_h     (src_h),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vhp_unit_bench.sv
module vhp_unit_bench;

    localparam int HW = 128;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op_sel = '0;
    logic [7:0]    imm = '0;
    logic          hsel = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [HW-1:0] src_h = '0;
    logic          out_valid, out_valid_r;
    logic [VW-1:0] result, result_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vhp_unit #(.HALF_W(HW), .OUT_REG(1'b0)) u_vhp_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .imm(imm), .hsel(hsel), .src_a(src_a), .src_b(src_b), .src_h(src_h),
        .out_valid(out_valid), .result(result)
    );

    vhp_unit #(.HALF_W(HW), .OUT_REG(1'b1)) u_vhp_unit_reg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .imm(imm), .hsel(hsel), .src_a(src_a), .src_b(src_b), .src_h(src_h),
        .out_valid(out_valid_r), .result(result_r)
    );

    function automatic logic [HW-1:0] pick(input logic [1:0] c,
                                           input logic [VW-1:0] a,
                                           input logic [VW-1:0] b);
        case (c)
            2'd0:    return a[HW-1:0];
            2'd1:    return a[VW-1:HW];
            2'd2:    return b[HW-1:0];
            default: return b[VW-1:HW];
        endcase
    endfunction

    function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [7:0] im,
                                            input logic hs, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b, input logic [HW-1:0] h);
        logic [HW-1:0] lo, hi;
        case (op)
            2'b00: begin
                lo = im[3] ? '0 : pick(im[1:0], a, b);
                hi = im[7] ? '0 : pick(im[5:4], a, b);
                return {hi, lo};
            end
            2'b01:   return hs ? {h, a[HW-1:0]} : {a[VW-1:HW], h};
            2'b10:   return {{HW{1'b0}}, (hs ? a[VW-1:HW] : a[HW-1:0])};
            default: return {h, h};
        endcase
    endfunction

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    task automatic new_data();
        for (int i = 0; i < 8; i++) begin
            src_a[i*32 +: 32] = $urandom;
            src_b[i*32 +: 32] = $urandom;
        end
        for (int i = 0; i < 4; i++) src_h[i*32 +: 32] = $urandom;
    endtask

    // Drives one operation on current data, checks both variants; returns comb result.
    task automatic run(input logic [1:0] op, input logic [7:0] im, input logic hs,
                       input string req, output logic [VW-1:0] got);
        logic [VW-1:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        op_sel = op;
        imm = im;
        hsel = hs;
        exp = model(op, im, hs, src_a, src_b, src_h);
        #1;
        got = result;
        chk(req, result, exp);
        chk({req, " valid"}, {255'd0, out_valid}, 256'd1);
        @(posedge clk);
        #1;
        chk({req, " reg"}, result_r, exp);
        chk({req, " reg valid"}, {255'd0, out_valid_r}, 256'd1);
    endtask

    task automatic t_reset();
        #1;
        chk("R8 reset reg valid", {255'd0, out_valid_r}, 256'd0);
        chk("R8 reset reg result", result_r, '0);
        chk("R8 comb valid idle", {255'd0, out_valid}, 256'd0);
    endtask

    task automatic t_perm_codes();
        logic [VW-1:0] g;
        for (int c = 0; c < 16; c++) begin
            new_data();
            run(2'b00, {2'b00, c[3:2], 2'b00, c[1:0]}, 1'b0, "R1 permute codes", g);
        end
    endtask

    task automatic t_perm_zero();
        logic [VW-1:0] g;
        for (int z = 0; z < 4; z++) begin
            new_data();
            run(2'b00, {z[1], 3'b011, z[0], 3'b010}, 1'b0, "R2 permute zero", g);
        end
    endtask

    task automatic t_perm_reserved();
        logic [VW-1:0] base, g;
        for (int c = 0; c < 4; c++) begin
            new_data();
            run(2'b00, {2'b00, c[1:0], 2'b00, ~c[1:0]}, 1'b0, "R3 baseline", base);
            run(2'b00, {2'b01, c[1:0], 2'b01, ~c[1:0]}, 1'b0, "R3 reserved set", g);
            chk("R3 reserved bits no effect", g, base);
        end
    endtask

    task automatic t_insert();
        logic [VW-1:0] g;
        for (int n = 0; n < 4; n++) begin
            new_data();
            run(2'b01, 8'h00, n[0], "R4 insert", g);
        end
    endtask

    task automatic t_extract();
        logic [VW-1:0] g;
        for (int n = 0; n < 4; n++) begin
            new_data();
            run(2'b10, 8'h00, n[0], "R5 extract", g);
        end
    endtask

    task automatic t_bcast();
        logic [VW-1:0] g;
        for (int n = 0; n < 3; n++) begin
            new_data();
            run(2'b11, 8'h00, 1'b0, "R6 broadcast", g);
        end
    endtask

    task automatic t_ignored();
        logic [VW-1:0] base, g;
        for (int op = 1; op < 4; op++) begin
            new_data();
            run(op[1:0], 8'h00, 1'b1, "R7 baseline", base);
            imm = 8'hFF;
            src_b = ~src_b;
            run(op[1:0], 8'hFF, 1'b1, "R7 imm and B changed", g);
            chk("R7 imm/B no effect", g, base);
        end
        new_data();
        run(2'b11, 8'h00, 1'b0, "R7 baseline", base);
        run(2'b11, 8'h00, 1'b1, "R7 hsel changed", g);
        chk("R7 hsel no effect broadcast", g, base);
        run(2'b00, 8'h31, 1'b0, "R7 baseline", base);
        src_h = ~src_h;
        run(2'b00, 8'h31, 1'b1, "R7 hsel/H changed", g);
        chk("R7 hsel/H no effect permute", g, base);
        run(2'b10, 8'h00, 1'b1, "R7 baseline", base);
        src_h = ~src_h;
        run(2'b10, 8'h00, 1'b1, "R7 H changed", g);
        chk("R7 H no effect extract", g, base);
    endtask

    task automatic t_latency();
        logic [VW-1:0] g, held;
        new_data();
        run(2'b11, 8'h00, 1'b0, "R8 load", g);
        held = result_r;
        @(negedge clk);
        in_valid = 1'b0;
        new_data();
        op_sel = 2'b10;
        #1;
        chk("R8 comb valid drops same cycle", {255'd0, out_valid}, 256'd0);
        chk("R8 comb result follows inputs", result,
            model(2'b10, imm, hsel, src_a, src_b, src_h));
        @(posedge clk);
        #1;
        chk("R8 reg valid low when idle", {255'd0, out_valid_r}, 256'd0);
        chk("R8 reg result held", result_r, held);
        @(posedge clk);
        #1;
        chk("R8 reg result still held", result_r, held);
    endtask

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_perm_codes();
        t_perm_zero();
        t_perm_reserved();
        t_insert();
        t_extract();
        t_bcast();
        t_ignored();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule